// File: doc/BRIEF.md
# Event Counter Bank with Dual-Mode Register Port

This block keeps eight 64-bit event counters and one 64-bit selector word. The selector word is split into eight byte-wide codes, where byte i (bits 8i+7 down to 8i) belongs to counter i. Each code names the event line that its counter follows. A counter adds one in every clock cycle in which its chosen line is high. It wraps to zero when it passes its largest value.

Software reaches the block through one register location. An access has two kinds. A scalar access reads or writes the selector word. A multiple access moves all eight counters as a burst, counter 0 first. Read rights and write rights are two separate inputs. A monitored thread can therefore be allowed to look at the counters without being able to change them. A refused access changes nothing. Its responses carry zero data and an error flag.

Top module: `pcs_set`

## Requirements
- R1: After reset all counters and the selector word are zero, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: A counter whose code k lies in 1..NUM_EVT adds one at every clock edge at which `evt_i[k-1]` is high.
- R3: A counter whose code is 0, or is greater than NUM_EVT, holds its value whatever the event lines do.
- R4: A permitted scalar read (`req_multi_i`=0, `req_write_i`=0) returns the selector word in the cycle after acceptance. That response has `rsp_last_o`=1 and `rsp_err_o`=0.
- R5: A permitted scalar write replaces the selector word with `req_wdata_i`. It is acknowledged in the next cycle with `rsp_err_o`=0, `rsp_last_o`=1 and zero data.
- R6: An accepted multiple read gives eight responses on eight consecutive cycles, starting the cycle after acceptance. They carry counters 0 to 7 in order. `rsp_last_o` is high only on the eighth. `req_ready_o` is low during the first seven.
- R7: A multiple write is one request beat followed by seven further accepted beats on `req_valid_i`. The beats load counters 0 to 7 in order. Each beat is answered in the next cycle, and the eighth answer has `rsp_last_o`=1.
- R8: A read issued with `perm_rd_i` low returns the same number of responses as a permitted read, each with zero data and `rsp_err_o`=1.
- R9: A write issued with `perm_wr_i` low leaves the selector word and every counter unchanged. Every one of its responses carries `rsp_err_o`=1.
- R10: Read and write rights act independently. With `perm_rd_i`=1 and `perm_wr_i`=0, reads succeed while writes are refused.
- R11: A counter holding all ones wraps to zero on its next counted event.
- R12: When a counter is loaded at the same edge at which its event is high, the loaded value wins and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event lines, one per selectable event |
| perm_rd_i | input | 1 | Read right for the requester |
| perm_wr_i | input | 1 | Write right for the requester |
| req_valid_i | input | 1 | Request or write data beat present |
| req_ready_o | output | 1 | Block can take a beat this cycle |
| req_write_i | input | 1 | Request is a write (sampled on the first beat) |
| req_multi_i | input | 1 | Request is a multiple access (sampled on the first beat) |
| req_wdata_i | input | BUS_W | Write data: selector word or counter value |
| rsp_valid_o | output | 1 | Response beat present |
| rsp_data_o | output | BUS_W | Read data, zero for writes and refused reads |
| rsp_err_o | output | 1 | Access refused for lack of rights |
| rsp_last_o | output | 1 | Final response of the access |

## Verification
The properties assume that the requester keeps `req_valid_i` high only for beats it means to send. They also assume that, once a multiple write has started, the next seven accepted beats are treated as data and not as new commands. The bench follows both rules. Every access is issued from a task that drops `req_valid_i` after its beats, and write bursts always run to eight beats. While the bench reads counters back, it holds every event line at zero, so each expected count comes only from the pulse patterns it drove earlier.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // Transfer state of the register port sequencer.
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_RD   = 2'd1,
        XF_WR   = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/pcs_event_sel.sv
module pcs_event_sel #(
    parameter int NUM_EVT = 16,
    parameter int SEL_W   = 8
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);

    // Code 0 and codes above NUM_EVT match no line.
    always_comb begin
        hit_o = 1'b0;
        for (int j = 0; j < NUM_EVT; j++) begin
            if (sel_i == SEL_W'(j + 1)) begin
                hit_o = evt_i[j];
            end
        end
    end

endmodule

// File: rtl/pcs_counter.sv
module pcs_counter #(
    parameter int CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CTR_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [CTR_W-1:0] val_o
);

    logic [CTR_W-1:0] val_d, val_q;

    // A load beats an increment at the same edge; the sum wraps.
    always_comb begin
        val_d = val_q;
        if (load_i) begin
            val_d = load_val_i;
        end else if (inc_i) begin
            val_d = val_q + CTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/pcs_xfer_seq.sv
module pcs_xfer_seq
    import pcs_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int BUS_W   = 64,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             perm_rd_i,
    input  logic             perm_wr_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             req_multi_i,
    input  logic [BUS_W-1:0] rd_data_i,
    output logic             req_ready_o,
    output logic             ctl_we_o,
    output logic             ctr_we_o,
    output logic [IDX_W-1:0] beat_idx_o,
    output logic             rd_ctl_o,
    output logic             rsp_valid_o,
    output logic [BUS_W-1:0] rsp_data_o,
    output logic             rsp_err_o,
    output logic             rsp_last_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTR - 1);

    typedef struct packed {
        xfer_mode_e       mode;
        logic [IDX_W-1:0] idx;
        logic             deny;
        logic             rsp_valid;
        logic [BUS_W-1:0] rsp_data;
        logic             rsp_err;
        logic             rsp_last;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_data  = '0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_last  = 1'b0;
        ctl_we_o       = 1'b0;
        ctr_we_o       = 1'b0;
        rd_ctl_o       = 1'b0;
        beat_idx_o     = st_q.idx;
        req_ready_o    = (st_q.mode != XF_RD);
        accept         = req_valid_i && req_ready_o;

        unique case (st_q.mode)
            XF_IDLE: begin
                if (accept) begin
                    st_d.rsp_valid = 1'b1;
                    beat_idx_o     = '0;
                    if (!req_multi_i) begin
                        st_d.rsp_last = 1'b1;
                        if (req_write_i) begin
                            ctl_we_o     = perm_wr_i;
                            st_d.rsp_err = !perm_wr_i;
                        end else begin
                            rd_ctl_o      = 1'b1;
                            st_d.rsp_err  = !perm_rd_i;
                            st_d.rsp_data = perm_rd_i ? rd_data_i : '0;
                        end
                    end else begin
                        st_d.idx = (NUM_CTR > 1) ? IDX_W'(1) : '0;
                        if (req_write_i) begin
                            st_d.deny    = !perm_wr_i;
                            ctr_we_o     = perm_wr_i;
                            st_d.rsp_err = !perm_wr_i;
                            st_d.mode    = (NUM_CTR > 1) ? XF_WR : XF_IDLE;
                        end else begin
                            st_d.deny     = !perm_rd_i;
                            st_d.rsp_err  = !perm_rd_i;
                            st_d.rsp_data = perm_rd_i ? rd_data_i : '0;
                            st_d.mode     = (NUM_CTR > 1) ? XF_RD : XF_IDLE;
                        end
                        st_d.rsp_last = (NUM_CTR == 1);
                    end
                end
            end
            XF_RD: begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_err   = st_q.deny;
                st_d.rsp_data  = st_q.deny ? '0 : rd_data_i;
                if (st_q.idx == LAST_IDX) begin
                    st_d.rsp_last = 1'b1;
                    st_d.mode     = XF_IDLE;
                    st_d.idx      = '0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
            XF_WR: begin
                if (req_valid_i) begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_err   = st_q.deny;
                    ctr_we_o       = !st_q.deny;
                    if (st_q.idx == LAST_IDX) begin
                        st_d.rsp_last = 1'b1;
                        st_d.mode     = XF_IDLE;
                        st_d.idx      = '0;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            default: begin
                st_d.mode = XF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: XF_IDLE, idx: '0, deny: 1'b0, rsp_valid: 1'b0,
                      rsp_data: '0, rsp_err: 1'b0, rsp_last: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_data_o  = st_q.rsp_data;
    assign rsp_err_o   = st_q.rsp_err;
    assign rsp_last_o  = st_q.rsp_last;

endmodule

// File: rtl/pcs_set.sv
module pcs_set #(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 64,
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 16,
    localparam int CTL_W  = NUM_CTR * SEL_W,
    localparam int BUS_W  = (CTL_W > CTR_W) ? CTL_W : CTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               perm_rd_i,
    input  logic               perm_wr_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic               req_write_i,
    input  logic               req_multi_i,
    input  logic [BUS_W-1:0]   req_wdata_i,
    output logic               rsp_valid_o,
    output logic [BUS_W-1:0]   rsp_data_o,
    output logic               rsp_err_o,
    output logic               rsp_last_o
);

    localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    logic [CTL_W-1:0] ctl_d, ctl_q;
    logic             ctl_we;
    logic             ctr_we;
    logic [IDX_W-1:0] beat_idx;
    logic             rd_ctl;
    logic [BUS_W-1:0] rd_data;
    logic [CTR_W-1:0] ctr_val [NUM_CTR];
    logic [NUM_CTR-1:0] ctr_hit;

    // Selector word register.
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we) begin
            ctl_d = req_wdata_i[CTL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // One selector and one counter per slot.
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        pcs_event_sel #(
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W)
        ) u_sel (
            .sel_i (ctl_q[i*SEL_W +: SEL_W]),
            .evt_i (evt_i),
            .hit_o (ctr_hit[i])
        );

        pcs_counter #(
            .CTR_W (CTR_W)
        ) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (ctr_we && (beat_idx == IDX_W'(i))),
            .load_val_i (req_wdata_i[CTR_W-1:0]),
            .inc_i      (ctr_hit[i]),
            .val_o      (ctr_val[i])
        );
    end

    // Read source: selector word for scalar reads, indexed counter otherwise.
    always_comb begin
        if (rd_ctl) begin
            rd_data = BUS_W'(ctl_q);
        end else begin
            rd_data = BUS_W'(ctr_val[beat_idx]);
        end
    end

    pcs_xfer_seq #(
        .NUM_CTR (NUM_CTR),
        .BUS_W   (BUS_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .perm_rd_i   (perm_rd_i),
        .perm_wr_i   (perm_wr_i),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_multi_i (req_multi_i),
        .rd_data_i   (rd_data),
        .req_ready_o (req_ready_o),
        .ctl_we_o    (ctl_we),
        .ctr_we_o    (ctr_we),
        .beat_idx_o  (beat_idx),
        .rd_ctl_o    (rd_ctl),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o),
        .rsp_err_o   (rsp_err_o),
        .rsp_last_o  (rsp_last_o)
    );

endmodule

// File: rtl/pcs_set_checker.sv
module pcs_set_checker #(
    parameter int NUM_CTR = 8,
    parameter int BUS_W   = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic             req_write_i,
    input logic             req_multi_i,
    input logic             rsp_valid_o,
    input logic [BUS_W-1:0] rsp_data_o,
    input logic             rsp_err_o,
    input logic             rsp_last_o
);

    localparam int LEFT_W = $clog2(NUM_CTR + 1);

    // Data beats still owed by a write burst, seen from the port side.
    logic [LEFT_W-1:0] wr_left_q;
    logic              acc;
    logic              cmd_acc;

    assign acc     = req_valid_i && req_ready_o;
    assign cmd_acc = acc && (wr_left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_left_q <= '0;
        end else if (cmd_acc && req_multi_i && req_write_i) begin
            wr_left_q <= LEFT_W'(NUM_CTR - 1);
        end else if (acc && wr_left_q != '0) begin
            wr_left_q <= wr_left_q - LEFT_W'(1);
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid_o && req_ready_o));

    a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> (rsp_valid_o && rsp_data_o == '0));

    a_r6_busy_streams: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready_o |-> (rsp_valid_o && !rsp_last_o));

    a_r4_scalar_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && !req_multi_i) |=> (rsp_valid_o && rsp_last_o));

    a_r7_beat_answered: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid_o);

    a_r7_write_burst_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_left_q != '0) |-> req_ready_o);

    a_r1_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last_o |-> rsp_valid_o);

endmodule

bind pcs_set pcs_set_checker #(
    .NUM_CTR (NUM_CTR),
    .BUS_W   (BUS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_multi_i (req_multi_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_last_o  (rsp_last_o)
);

// File: tb/pcs_set_test.sv
module pcs_set_test;

    localparam int NC = 8;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt = '0;
    logic          perm_rd = 1'b1;
    logic          perm_wr = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_multi = 1'b0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          rsp_err;
    logic          rsp_last;

    int checks = 0;
    int failures = 0;

    logic [63:0] exp_ctr [NC];
    logic [63:0] b_data [NC];
    logic        b_err [NC];
    logic        b_last [NC];
    logic        b_valid [NC];
    logic        b_ready [NC];
    logic [63:0] s_data;
    logic        s_err, s_last, s_valid;
    logic [63:0] ctl_word;

    always #4 clk = ~clk;

    pcs_set uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .perm_rd_i   (perm_rd),
        .perm_wr_i   (perm_wr),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_write_i (req_write),
        .req_multi_i (req_multi),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .rsp_err_o   (rsp_err),
        .rsp_last_o  (rsp_last)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic scalar(input logic wr, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_multi = 1'b0; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        s_data = rsp_data; s_err = rsp_err; s_last = rsp_last; s_valid = rsp_valid;
    endtask

    task automatic multi_read();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_multi = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_multi = 1'b0;
        for (int k = 0; k < NC; k++) begin
            if (k > 0) @(negedge clk);
            b_data[k] = rsp_data; b_err[k] = rsp_err; b_last[k] = rsp_last;
            b_valid[k] = rsp_valid; b_ready[k] = req_ready;
        end
    endtask

    task automatic multi_write(input logic [63:0] v [NC], input logic pulse_all);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_multi = 1'b1; req_wdata = v[0];
        if (pulse_all) evt = '1;
        for (int k = 1; k < NC; k++) begin
            @(negedge clk);
            evt = '0;
            b_data[k-1] = rsp_data; b_err[k-1] = rsp_err; b_last[k-1] = rsp_last;
            b_valid[k-1] = rsp_valid;
            req_write = 1'b0; req_multi = 1'b0; req_wdata = v[k];
        end
        @(negedge clk);
        req_valid = 1'b0;
        b_data[NC-1] = rsp_data; b_err[NC-1] = rsp_err; b_last[NC-1] = rsp_last;
        b_valid[NC-1] = rsp_valid;
    endtask

    task automatic check_read_burst(input string tag);
        for (int k = 0; k < NC; k++) begin
            check($sformatf("%s beat%0d data", tag, k), b_data[k], exp_ctr[k]);
            check($sformatf("%s beat%0d valid/err", tag, k), {62'd0, b_valid[k], b_err[k]}, 64'd2);
            check($sformatf("%s beat%0d last", tag, k), {63'd0, b_last[k]}, {63'd0, k == NC - 1});
            check($sformatf("%s beat%0d ready", tag, k), {63'd0, b_ready[k]}, {63'd0, k == NC - 1});
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] wv [NC];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        check("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
        for (int i = 0; i < NC; i++) exp_ctr[i] = '0;
        multi_read();
        check_read_burst("R1 R6 zero counters");
        scalar(1'b0, '0);
        check("R1 selector zero", s_data, 64'd0);

        // R5 / R4: write then read back the selector word.
        // Counter i uses code i+1 (line i), counter 6 code 0, counter 7 code 200.
        ctl_word = '0;
        for (int i = 0; i < 6; i++) ctl_word[i*8 +: 8] = 8'(i + 1);
        ctl_word[63:56] = 8'd200;
        scalar(1'b1, ctl_word);
        check("R5 write ack err/last/valid", {61'd0, s_valid, s_err, s_last}, 64'd5);
        check("R5 write ack data", s_data, 64'd0);
        scalar(1'b0, '0);
        check("R4 read selector", s_data, ctl_word);
        check("R4 read err/last/valid", {61'd0, s_valid, s_err, s_last}, 64'd5);

        // R2 / R3: line j pulses at cycles where c mod (j+1) == 0.
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            for (int j = 0; j < NE; j++) evt[j] = ((c % (j + 1)) == 0);
        end
        @(negedge clk);
        evt = '0;
        for (int i = 0; i < NC; i++) exp_ctr[i] = (i < 6) ? 64'((20 + i) / (i + 1)) : 64'd0;
        multi_read();
        check_read_burst("R2 R3 R6 counts");

        // R8: reads refused.
        perm_rd = 1'b0;
        multi_read();
        for (int k = 0; k < NC; k++) begin
            check($sformatf("R8 refused beat%0d data", k), b_data[k], 64'd0);
            check($sformatf("R8 refused beat%0d err/valid", k), {62'd0, b_valid[k], b_err[k]}, 64'd3);
        end
        check("R8 refused burst last", {63'd0, b_last[NC-1]}, 64'd1);
        scalar(1'b0, '0);
        check("R8 refused scalar", {s_data[61:0], s_err, s_last}, 64'd3);

        // R9 / R10: read allowed, write refused.
        perm_rd = 1'b1; perm_wr = 1'b0;
        scalar(1'b1, 64'hDEAD_BEEF_0000_1111);
        check("R9 refused scalar write err", {62'd0, s_err, s_last}, 64'd3);
        scalar(1'b0, '0);
        check("R10 read while write refused", s_data, ctl_word);
        check("R10 read not flagged", {63'd0, s_err}, 64'd0);
        for (int k = 0; k < NC; k++) wv[k] = 64'hAAAA_0000_0000_0000 + 64'(k);
        multi_write(wv, 1'b0);
        for (int k = 0; k < NC; k++)
            check($sformatf("R9 refused burst beat%0d err/valid", k), {62'd0, b_valid[k], b_err[k]}, 64'd3);
        multi_read();
        check_read_burst("R9 counters untouched");

        // R7: permitted burst write, counter 0 loaded with all ones.
        perm_wr = 1'b1;
        for (int k = 0; k < NC; k++) wv[k] = (k == 0) ? '1 : 64'h0123_4567_89AB_CDE0 + 64'(k);
        multi_write(wv, 1'b0);
        for (int k = 0; k < NC; k++) begin
            check($sformatf("R7 write beat%0d err/valid", k), {62'd0, b_valid[k], b_err[k]}, 64'd2);
            check($sformatf("R7 write beat%0d last", k), {63'd0, b_last[k]}, {63'd0, k == NC - 1});
            exp_ctr[k] = wv[k];
        end
        multi_read();
        check_read_burst("R7 loaded");

        // R11: one pulse on line 0 wraps counter 0.
        @(negedge clk); evt = 16'h0001;
        @(negedge clk); evt = '0;
        exp_ctr[0] = 64'd0;
        multi_read();
        check_read_burst("R11 wrap");

        // R12: all lines high at the edge that loads counter 0.
        for (int k = 0; k < NC; k++) begin
            wv[k] = 64'(k * 3 + 5);
            exp_ctr[k] = wv[k];
        end
        multi_write(wv, 1'b1);
        multi_read();
        check_read_burst("R12 load wins");

        summary();
        $finish;
    end

endmodule